// File: doc/BRIEF.md
# Sector Protection Gate

This block keeps one protection bit for each sector of a memory array and, for each program or erase request, decides whether the operation may go ahead. Each decision comes out one clock after the request as a single-cycle grant pulse or a single-cycle deny pulse. A separate load port sets or clears each sector's bit. After reset every sector is unprotected.

An elevated-reset indication comes from analog detection outside this block and arrives here as a plain digital input. While it is active, all stored protection is lifted for the time being. The stored bits are never changed, so protection comes back in full once the indication drops.

An active-low write-protect input limits that lift. While write-protect is low, the first sector and the last sector keep their protection even during the lift. Requests whose index is past the last sector are always refused.

Top module: `sect_guard`

## Requirements
- R1: During and right after a synchronous reset, grant and deny are low and every sector's protection bit is clear, so a request to any sector is granted.
- R2: A request sampled at a clock edge produces its verdict in the cycle after that edge, as a pulse one cycle long. When no request was sampled at the previous edge, grant and deny are both low.
- R3: Each request yields exactly one of grant or deny, and the two are never high together.
- R4: A request to a protected sector while the elevated-reset input is low is denied.
- R5: A request to an unprotected, in-range sector is granted, whatever the levels of the elevated-reset and write-protect inputs.
- R6: While elevated-reset is high and write-protect is high, a request to any in-range protected sector is granted.
- R7: While elevated-reset is high and write-protect is low, a protected sector 0 or a protected sector N_SECT-1 is denied, and protected sectors between them are granted.
- R8: The lift does not change the stored bits. Once elevated-reset is low again, every sector that was protected before is denied again.
- R9: A load with the write strobe high writes the value bit into the bit of the addressed sector (1 = protected, 0 = unprotected). A load whose index is N_SECT or more changes no sector.
- R10: A request whose sector index is N_SECT or more is denied.
- R11: When a load and a request happen in the same cycle, the request is decided on the bit as it was before that load. The new value applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_we | input | 1 | Load strobe for one protection bit |
| flag_idx | input | IDX_W | Sector index of the load |
| flag_val | input | 1 | Value to load (1 = protected) |
| op_req | input | 1 | Program/erase request strobe |
| op_idx | input | IDX_W | Sector index of the request |
| hv_unlock | input | 1 | Elevated-reset indication; lifts protection while high |
| wp_n | input | 1 | Write-protect, active low; holds the outer sectors |
| grant | output | 1 | One-cycle pulse: operation allowed |
| deny | output | 1 | One-cycle pulse: operation refused |

## Verification
The bench loads all 64 protection patterns of a six-sector configuration. For each pattern it sends requests to every index, including the two indices past the last sector, under all four combinations of the elevated-reset and write-protect levels. Requests with the lift active come before requests with it inactive, so a design that cleared or rewrote the stored bits during the lift would grant sectors it should deny once the lift ends. A design that applied the write-protect exemption to every sector, or to none, would get the inner or the outer sectors wrong. A design that aliased out-of-range indices onto real sectors would grant indices 6 and 7 or corrupt a real bit. A same-cycle load and request checks that the decision uses the bit from before the load, and the cycle after each verdict is checked to be idle, which catches a verdict held for more than one cycle.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    VD_NONE  = 2'd0,
    VD_GRANT = 2'd1,
    VD_DENY  = 2'd2
  } verdict_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sg_flag_bank.sv
module sg_flag_bank #(
  parameter int N_SECT = 6,
  localparam int IDX_W = sg_pkg::idx_bits(N_SECT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_val,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_prot,
  output logic              rd_valid,
  output logic [N_SECT-1:0] prot_vec
);
  // one register per sector, each with its own write decode
  for (genvar g = 0; g < N_SECT; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        prot_vec[g] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        prot_vec[g] <= wr_val;
    end
  end

  always_comb begin
    rd_valid = (int'(rd_idx) < N_SECT);
    rd_prot  = 1'b0;
    for (int i = 0; i < N_SECT; i++)
      if (rd_idx == IDX_W'(i))
        rd_prot = prot_vec[i];
  end
endmodule

// File: rtl/sg_lift.sv
module sg_lift #(
  parameter int N_SECT = 6,
  localparam int IDX_W = sg_pkg::idx_bits(N_SECT),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SECT - 1)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             hv_unlock,
  input  logic             wp_n,
  output logic             lift
);
  logic outer;

  always_comb begin
    outer = (idx == '0) || (idx == LAST_IDX);
    // the lift applies unless write-protect holds an outer sector
    lift  = hv_unlock && !(!wp_n && outer);
  end
endmodule

// File: rtl/sg_verdict.sv
module sg_verdict
  import sg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic valid,
  input  logic prot,
  input  logic lift,
  output logic grant,
  output logic deny
);
  verdict_e nxt;

  always_comb begin
    if (!req)
      nxt = VD_NONE;
    else if (!valid)
      nxt = VD_DENY;
    else if (prot && !lift)
      nxt = VD_DENY;
    else
      nxt = VD_GRANT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= (nxt == VD_GRANT);
      deny  <= (nxt == VD_DENY);
    end
  end
endmodule

// File: rtl/sect_guard.sv
module sect_guard #(
  parameter int N_SECT = 6,
  localparam int IDX_W = sg_pkg::idx_bits(N_SECT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flag_we,
  input  logic [IDX_W-1:0] flag_idx,
  input  logic             flag_val,
  input  logic             op_req,
  input  logic [IDX_W-1:0] op_idx,
  input  logic             hv_unlock,
  input  logic             wp_n,
  output logic             grant,
  output logic             deny
);
  logic              sel_prot;
  logic              sel_valid;
  logic              sel_lift;
  logic [N_SECT-1:0] prot_vec;

  sg_flag_bank #(.N_SECT(N_SECT)) bank_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (flag_we),
    .wr_idx   (flag_idx),
    .wr_val   (flag_val),
    .rd_idx   (op_idx),
    .rd_prot  (sel_prot),
    .rd_valid (sel_valid),
    .prot_vec (prot_vec)
  );

  sg_lift #(.N_SECT(N_SECT)) lift_i (
    .idx       (op_idx),
    .hv_unlock (hv_unlock),
    .wp_n      (wp_n),
    .lift      (sel_lift)
  );

  sg_verdict verdict_i (
    .clk   (clk),
    .rst   (rst),
    .req   (op_req),
    .valid (sel_valid),
    .prot  (sel_prot),
    .lift  (sel_lift),
    .grant (grant),
    .deny  (deny)
  );
endmodule

// File: rtl/sect_guard_chk.sv
module sect_guard_chk #(
  parameter int N_SECT = 6,
  localparam int IDX_W = sg_pkg::idx_bits(N_SECT)
) (
  input logic              clk,
  input logic              rst,
  input logic              op_req,
  input logic [IDX_W-1:0]  op_idx,
  input logic              hv_unlock,
  input logic              wp_n,
  input logic              grant,
  input logic              deny,
  input logic [N_SECT-1:0] prot_vec
);
  logic in_rng, at_prot, outer;

  always_comb begin
    in_rng  = (int'(op_idx) < N_SECT);
    outer   = (int'(op_idx) == 0) || (int'(op_idx) == N_SECT - 1);
    at_prot = 1'b0;
    for (int i = 0; i < N_SECT; i++)
      if (int'(op_idx) == i) at_prot = prot_vec[i];
  end

  a_r2_only_after_req: assert property (@(posedge clk) disable iff (rst)
    (grant || deny) |-> $past(op_req));
  a_r3_one_verdict: assert property (@(posedge clk) disable iff (rst)
    op_req |=> (grant ^ deny));
  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(grant && deny));
  a_r4_locked_deny: assert property (@(posedge clk) disable iff (rst)
    (op_req && in_rng && at_prot && !hv_unlock) |=> deny);
  a_r5_open_grant: assert property (@(posedge clk) disable iff (rst)
    (op_req && in_rng && !at_prot) |=> grant);
  a_r6_lift_grant: assert property (@(posedge clk) disable iff (rst)
    (op_req && in_rng && hv_unlock && wp_n) |=> grant);
  a_r7_outer_held: assert property (@(posedge clk) disable iff (rst)
    (op_req && in_rng && at_prot && hv_unlock && !wp_n && outer) |=> deny);
  a_r10_range_deny: assert property (@(posedge clk) disable iff (rst)
    (op_req && !in_rng) |=> deny);
endmodule

bind sect_guard sect_guard_chk #(.N_SECT(N_SECT)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .op_req    (op_req),
  .op_idx    (op_idx),
  .hv_unlock (hv_unlock),
  .wp_n      (wp_n),
  .grant     (grant),
  .deny      (deny),
  .prot_vec  (prot_vec)
);

// File: tb/sect_guard_tb_top.sv
module sect_guard_tb_top;
  localparam int N = 6;
  localparam int W = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic flag_we = 1'b0, flag_val = 1'b0;
  logic [W-1:0] flag_idx = '0, op_idx = '0;
  logic op_req = 1'b0, hv_unlock = 1'b0, wp_n = 1'b1;
  logic grant, deny;

  sect_guard #(.N_SECT(N)) dut_i (
    .clk(clk), .rst(rst), .flag_we(flag_we), .flag_idx(flag_idx),
    .flag_val(flag_val), .op_req(op_req), .op_idx(op_idx),
    .hv_unlock(hv_unlock), .wp_n(wp_n), .grant(grant), .deny(deny)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic model [8];

  task automatic check(input string tag, input logic g, input logic d,
                       input logic eg, input logic ed);
    n_cmp++;
    if (g !== eg || d !== ed) begin
      n_bad++;
      $display("FAIL %s grant/deny=%b%b expected %b%b", tag, g, d, eg, ed);
    end
  endtask

  task automatic load(input int idx, input logic v);
    @(negedge clk);
    flag_we = 1'b1; flag_idx = idx[W-1:0]; flag_val = v;
    @(negedge clk);
    flag_we = 1'b0;
    if (idx < N) model[idx] = v;
  endtask

  task automatic req(input int idx, input logic hv, input logic wp, input string tag);
    logic eg, p, lift;
    if (idx >= N) eg = 1'b0;
    else begin
      p    = model[idx];
      lift = hv && !(!wp && (idx == 0 || idx == N - 1));
      eg   = !p || lift;
    end
    @(negedge clk);
    op_req = 1'b1; op_idx = idx[W-1:0]; hv_unlock = hv; wp_n = wp;
    @(negedge clk);
    op_req = 1'b0;
    check(tag, grant, deny, eg, !eg);
    @(negedge clk);
    check("R2 idle", grant, deny, 1'b0, 1'b0);
  endtask

  function automatic string pick_tag(int idx, logic p, logic hv, logic wp);
    if (idx >= N) return "R10";
    if (!p) return "R5";
    if (!hv) return "R8";
    if (wp) return "R6";
    return "R7";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", grant, deny, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", grant, deny, 1'b0, 1'b0);
    for (int s = 0; s < N; s++) req(s, 1'b0, 1'b0, "R1");

    // R9 set then clear; R4 deny outside the lift
    load(3, 1'b1);
    req(3, 1'b0, 1'b1, "R4");
    load(3, 1'b0);
    req(3, 1'b0, 1'b1, "R9");
    // R9 out-of-range load touches nothing
    load(7, 1'b1);
    load(6, 1'b1);
    for (int s = 0; s < N; s++) req(s, 1'b0, 1'b1, "R9");

    // R11 same-cycle load and request
    @(negedge clk);
    flag_we = 1'b1; flag_idx = 3'd2; flag_val = 1'b1;
    op_req = 1'b1; op_idx = 3'd2; hv_unlock = 1'b0; wp_n = 1'b1;
    @(negedge clk);
    flag_we = 1'b0; op_req = 1'b0;
    check("R11 old value", grant, deny, 1'b1, 1'b0);
    model[2] = 1'b1;
    req(2, 1'b0, 1'b1, "R11");

    // full sweep: all patterns, lift first then normal level (R8)
    for (int pat = 0; pat < 64; pat++) begin
      for (int s = 0; s < N; s++) load(s, pat[s]);
      for (int hv = 1; hv >= 0; hv--)
        for (int wp = 0; wp < 2; wp++)
          for (int idx = 0; idx < 8; idx++)
            req(idx, hv[0], wp[0],
                pick_tag(idx, (idx < N) ? model[idx] : 1'b0, hv[0], wp[0]));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule